// File: doc/BRIEF.md
# Four-Phase Step Sequencer

This block paces an iterative datapath that does one step per pass, each pass split into four phases. A one-hot ring register walks a single set bit across four phase strobes, one position per clock. The last strobe wraps back to the first. A datapath hooked to the strobes can therefore load operands, move shifted values and commit a partial result in a fixed order on every pass.

A rising edge on the start request loads the ring with the first phase and clears the pass counter. It also raises a flag that marks the first pass, so the datapath can take its operands from the outside world rather than from its own registers. The flag drops once the first pass has finished its fourth phase.

The pass counter steps once at the end of every fourth phase. Its most significant bit serves directly as the completion flag, so eight passes end the run. When the run completes, the ring empties and the strobes stay quiet until the next start request.

Top module: `phase_sequencer`

## Requirements
- R1: While reset is held and on release, `phase` is 4'b0000, `init_pass` is 0, `pass_count` is 0 and `done` is 0; no strobe rises until a start request is seen.
- R2: A 0-to-1 change of `start_req`, sampled at a clock edge, makes that edge load `phase` with 4'b0001, `pass_count` with 0 and `init_pass` with 1. Keeping `start_req` high does not start again.
- R3: While running, each clock edge moves the single set bit of `phase` from bit i to bit i+1, and from bit 3 back to bit 0. At most one bit of `phase` is ever set.
- R4: `pass_count` goes up by one on each edge at which `phase[3]` is set, and on no other edge.
- R5: `init_pass` clears on the edge that ends the first phase 3 after a start, and stays 0 for the rest of the run.
- R6: `done` equals `pass_count[3]`. On the 32nd edge after the start edge, `pass_count` becomes 8, `done` becomes 1 and `phase` becomes 4'b0000. All three hold until the next start.
- R7: A start request in the middle of a run, or after `done`, restarts the sequence exactly as in R2 and clears `done`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Synchronous reset, active low |
| start_req | input | 1 | Start request; its rising edge begins a run |
| phase | output | 4 | One-hot phase strobes, bit i is phase i |
| init_pass | output | 1 | High during the first pass of a run |
| pass_count | output | 4 | Number of completed passes |
| done | output | 1 | Run complete (bit 3 of the pass count) |

## Verification
Every output is a register, so each result of a start request is due one edge later. If the start edge is called edge 0, then after edge n the bench expects `phase` to be bit n mod 4 and `pass_count` to be n/4. It expects `init_pass` only while n is below 4, and expects `done` with an empty ring from n = 32 on. The bench changes inputs on falling edges and compares all outputs on the falling edge that follows each rising edge. That way every check sees the state after a known number of edges and never a value that is still settling. The restart scenarios reset n to zero at the edge that sees the new rising start request, and compare against the same schedule from there.

// File: rtl/phase_sequencer.sv
module phase_sequencer #(
  parameter int PHASES = 4,
  parameter int CNT_W  = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_req,
  output logic [PHASES-1:0] phase,
  output logic              init_pass,
  output logic [CNT_W-1:0]  pass_count,
  output logic              done
);
  localparam int LAST     = PHASES - 1;
  localparam int DONE_BIT = CNT_W - 1;
  localparam logic [PHASES-1:0] FIRST = {{(PHASES-1){1'b0}}, 1'b1};
  localparam logic [CNT_W-1:0]  ONE   = {{(CNT_W-1){1'b0}}, 1'b1};

  logic              start_q;
  logic              start_rise;
  logic [CNT_W-1:0]  cnt_next;
  logic [PHASES-1:0] ring_next;

  assign start_rise = start_req & ~start_q;
  assign cnt_next   = pass_count + ONE;
  assign ring_next  = {phase[LAST-1:0], phase[LAST]};
  assign done       = pass_count[DONE_BIT];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      start_q    <= 1'b0;
      phase      <= '0;
      init_pass  <= 1'b0;
      pass_count <= '0;
    end else begin
      start_q <= start_req;
      if (start_rise) begin
        phase      <= FIRST;
        init_pass  <= 1'b1;
        pass_count <= '0;
      end else if (phase != '0 && !done) begin
        if (phase[LAST]) begin
          pass_count <= cnt_next;
          init_pass  <= 1'b0;
          phase      <= cnt_next[DONE_BIT] ? '0 : ring_next;
        end else begin
          phase <= ring_next;
        end
      end
    end
  end

  AST_ONE_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(phase)); // R3
  AST_START_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    start_rise |=> (phase == FIRST && init_pass && pass_count == '0)); // R2
  AST_SHIFT_UP: assert property (@(posedge clk) disable iff (!rst_n)
    (phase != '0 && !phase[LAST] && !start_rise) |=> (phase == ($past(phase) << 1))); // R3
  AST_PASS_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (phase[LAST] && !start_rise) |=> (pass_count == $past(pass_count) + ONE)); // R4
  AST_PASS_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!phase[LAST] && !start_rise) |=> $stable(pass_count)); // R4
  AST_INIT_DROP: assert property (@(posedge clk) disable iff (!rst_n)
    (phase[LAST] && !start_rise) |=> !init_pass); // R5
  AST_DONE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (phase == '0)); // R6
endmodule

// File: tb/phase_sequencer_bench.sv
`timescale 1ns/1ps
module phase_sequencer_bench;
  logic       clk = 1'b0;
  logic       rst_n;
  logic       start_req;
  logic [3:0] phase;
  logic       init_pass;
  logic [3:0] pass_count;
  logic       done;

  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;

  phase_sequencer u_phase_sequencer (
    .clk(clk), .rst_n(rst_n), .start_req(start_req),
    .phase(phase), .init_pass(init_pass), .pass_count(pass_count), .done(done)
  );

  always #5 clk = ~clk;

  function automatic logic [9:0] expect_at(int n);
    logic [3:0] p;
    logic [3:0] c;
    logic       ini;
    logic       d;
    if (n >= 32) begin
      p = 4'b0000; c = 4'd8; ini = 1'b0; d = 1'b1;
    end else begin
      p = 4'b0001 << (n % 4); c = 4'(n / 4); ini = (n < 4); d = 1'b0;
    end
    return {p, ini, c, d};
  endfunction

  task automatic check(string req, logic [9:0] exp);
    logic [9:0] act;
    act = {phase, init_pass, pass_count, done};
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: got phase=%b init=%b count=%0d done=%b, expected phase=%b init=%b count=%0d done=%b",
               req, act[9:6], act[5], act[4:1], act[0], exp[9:6], exp[5], exp[4:1], exp[0]);
    end
  endtask

  task automatic start_edge();
    @(negedge clk) start_req = 1'b1;
    @(negedge clk) start_req = 1'b0;
  endtask

  task automatic t_reset();
    rst_n = 1'b0; start_req = 1'b0;
    repeat (3) @(negedge clk);
    check("R1 in reset", 10'b0000_0_0000_0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check("R1 idle after reset", 10'b0000_0_0000_0);
  endtask

  task automatic t_full_run();
    start_edge();
    check("R2 start load", expect_at(0));
    for (int n = 1; n <= 36; n++) begin
      @(negedge clk);
      if (n < 4)       check("R3 R5 first pass", expect_at(n));
      else if (n < 32) check("R3 R4 rotation/count", expect_at(n));
      else             check("R6 done and quiet", expect_at(n));
    end
  endtask

  task automatic t_level_hold();
    @(negedge clk) start_req = 1'b1;
    @(negedge clk);
    check("R7 start after done", expect_at(0));
    for (int n = 1; n <= 6; n++) begin
      @(negedge clk);
      check("R2 held level no retrigger", expect_at(n));
    end
    start_req = 1'b0;
    for (int n = 7; n <= 9; n++) begin
      @(negedge clk);
      check("R4 count after level drop", expect_at(n));
    end
  endtask

  task automatic t_restart_mid();
    start_edge();
    check("R7 mid-run restart", expect_at(0));
    for (int n = 1; n <= 33; n++) begin
      @(negedge clk);
      if (n == 4 || n == 32) check("R5 R6 restarted run", expect_at(n));
    end
  endtask

  initial begin
    t_reset();
    t_full_run();
    t_level_hold();
    t_restart_mid();
    finished = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #2000000;
    if (!finished) begin
      checks++;
      errors++;
      $display("FAIL watchdog: got no finish, expected finish");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule